// File: doc/BRIEF.md
# Serial Control Word Receiver for a Six-Channel Volume and Tone Block

This block sits between a host microcontroller and the control registers of a six-channel analog volume stage with two-band tone control. The host sends 24-bit words over a two-wire link made of a serial clock and a data line. The receiver oversamples both wires with the faster system clock. It shifts in one data bit on each rising serial clock. It recognises the commit gesture made on the data line and then writes the word into one of four register groups. A slot code carried in the last bits of the word selects the group.

The registers hold a bass code and a treble code, and a gain code and a volume code for each channel. The block turns these codes into values the analog side can use directly: a signed tone setting in dB with a bypass flag for each band, a gain in dB, an attenuation in dB and a mute flag for each channel. It also gives a one-cycle strobe that names the group just written. A power-good input holds every register at its power-up value and blocks frames while it is low.

Top module: `actl_rx`

## Requirements
- R1: The data line is sampled on each rising edge of the serial clock. A frame is 24 bits long, and the first bit sent is bit D0.
- R2: A commit happens in two steps. First the serial clock falls while data is high. Then data falls while the serial clock is still low. Every commit clears the bit counter, so the next frame starts counting from zero.
- R3: A commit that follows any bit count other than exactly 24 discards the frame. No register changes and no strobe is given.
- R4: D22 (most significant) and D23 form the slot select. 00 selects tone, 01 selects channels 0/1, 10 selects channels 2/3 and 11 selects channels 4/5. A frame with any of D18..D21 set is dropped with no effect.
- R5: In the tone slot, bass is the code D8..D11 and treble is the code D12..D15, first bit most significant. Code 0000 sets bypass with a setting of 0 dB. A code 1mmm gives +2*m dB. A code 0mmm with m from 1 to 7 gives -2*m dB.
- R6: In a channel slot, the even channel takes its gain from D0..D1 and its volume from D2..D8. The odd channel takes its gain from D9..D10 and its volume from D11..D17. In each field the first bit is the most significant. The gain is 6 dB times the gain code.
- R7: A volume code from 0 to 99 gives that attenuation in dB with mute low. A code above 99 sets mute and reports an attenuation of 99.
- R8: After reset, and whenever power-good is low, both tone bands are in bypass, every gain is 0 dB and every channel is muted. Frames sent while power-good is low are ignored.
- R9: Each accepted frame gives exactly one strobe cycle, with the slot code on the slot output. Dropped frames give no strobe.
- R10: Registers of groups not addressed by an accepted frame keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power-good: low holds defaults and blocks frames |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dat | input | 1 | Serial data from the host |
| bass_byp | output | 1 | Bass band bypassed |
| bass_db | output | 5 | Signed bass setting in dB |
| treb_byp | output | 1 | Treble band bypassed |
| treb_db | output | 5 | Signed treble setting in dB |
| gain_db | output | 6x5 | Gain in dB for each channel |
| atten_db | output | 6x7 | Attenuation in dB for each channel |
| mute | output | 6 | Mute flag for each channel |
| upd_stb | output | 1 | One-cycle pulse after an accepted frame |
| upd_slot | output | 2 | Slot code of the frame just accepted |

## Verification
The assertions assume that the serial clock and the data line never change in the same system cycle. They also assume that each level lasts long enough to pass the two-flop synchronizer. Data may change only while the serial clock is high. The one exception is the commit fall, which happens while the clock is low; a rise of the data line while the clock is low is also allowed. The bench drives every wire change on its own, holds each level for six system cycles and follows that change rule, so the random frames never produce a false commit. The random frames and the short, long, reserved-bit and power-low cases all stay inside these assumptions.

// File: rtl/actl_pkg.sv
package actl_pkg;

   localparam int FRAME_W   = 24;
   localparam int SLOT_MSB  = 22;
   localparam int SLOT_LSB  = 23;
   localparam int RSVD_LO   = 18;
   localparam int RSVD_HI   = 21;
   localparam int BASS_LO   = 8;
   localparam int TREB_LO   = 12;
   localparam int TONE_W    = 4;
   localparam int GAIN_W    = 2;
   localparam int CH_STRIDE = 9;

   typedef enum logic [1:0] {
      SLOT_TONE  = 2'b00,
      SLOT_FRONT = 2'b01,
      SLOT_MID   = 2'b10,
      SLOT_REAR  = 2'b11
   } slot_e;

endpackage

// File: rtl/actl_sync.sv
module actl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic q,
   output logic q_d
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $fatal(1, "actl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], din};
   end

   assign q   = pipe[STAGES-1];
   assign q_d = pipe[STAGES];
endmodule

// File: rtl/actl_frame_rx.sv
module actl_frame_rx
   import actl_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               sclk,
   input  logic               sclk_d,
   input  logic               sdat,
   input  logic               sdat_d,
   output logic               commit,
   output logic [FRAME_W-1:0] frame
);
   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

   logic               sclk_rise, sclk_fall, sdat_fall, latch_evt;
   logic               armed;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] shreg;

   assign sclk_rise = sclk & ~sclk_d;
   assign sclk_fall = ~sclk & sclk_d;
   assign sdat_fall = ~sdat & sdat_d;
   assign latch_evt = en & armed & sdat_fall & ~sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         armed  <= 1'b0;
         commit <= 1'b0;
         shreg  <= '0;
         frame  <= '0;
      end else if (!en) begin
         cnt    <= '0;
         armed  <= 1'b0;
         commit <= 1'b0;
      end else begin
         commit <= 1'b0;
         if (sclk_rise) begin
            shreg <= {sdat, shreg[FRAME_W-1:1]};
            armed <= 1'b0;
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
         end else if (sclk_fall && sdat) begin
            armed <= 1'b1;
         end else if (latch_evt) begin
            armed  <= 1'b0;
            cnt    <= '0;
            commit <= (cnt == CNT_FULL);
            frame  <= shreg;
         end
      end
   end

   AST_LATCH_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      latch_evt |=> (cnt == '0)); // R2
   AST_BAD_COUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_evt && cnt != CNT_FULL) |=> !commit); // R3
   AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit); // R9
endmodule

// File: rtl/actl_regfile.sv
module actl_regfile
   import actl_pkg::*;
#(
   parameter int NCH   = 6,
   parameter int VOL_W = 7
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  logic                        commit,
   input  logic [FRAME_W-1:0]          frame,
   output logic [TONE_W-1:0]           bass_c,
   output logic [TONE_W-1:0]           treb_c,
   output logic [NCH-1:0][GAIN_W-1:0]  gain_c,
   output logic [NCH-1:0][VOL_W-1:0]   vol_c,
   output logic                        upd_stb,
   output logic [1:0]                  upd_slot
);
   generate
      if (VOL_W + GAIN_W != CH_STRIDE) begin : g_bad_vol
         $fatal(1, "actl_regfile: VOL_W plus GAIN_W must fill a channel field");
      end
      if (NCH % 2 != 0 || NCH > 6 || NCH < 2) begin : g_bad_nch
         $fatal(1, "actl_regfile: NCH must be 2, 4 or 6");
      end
   endgenerate

   logic        accept;
   logic [1:0]  slot;
   logic [TONE_W-1:0] bass_f, treb_f;

   assign slot   = {frame[SLOT_MSB], frame[SLOT_LSB]};
   assign accept = commit & en & ~(|frame[RSVD_HI:RSVD_LO]);

   always_comb begin
      for (int k = 0; k < TONE_W; k++) begin
         bass_f[TONE_W-1-k] = frame[BASS_LO+k];
         treb_f[TONE_W-1-k] = frame[TREB_LO+k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bass_c <= '0;
         treb_c <= '0;
      end else if (!en) begin
         bass_c <= '0;
         treb_c <= '0;
      end else if (accept && slot == SLOT_TONE) begin
         bass_c <= bass_f;
         treb_c <= treb_f;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      localparam int BASE = (c % 2) * CH_STRIDE;
      localparam logic [1:0] MY_SLOT = 2'(c / 2 + 1);
      logic [GAIN_W-1:0] g_f;
      logic [VOL_W-1:0]  v_f;

      always_comb begin
         for (int k = 0; k < GAIN_W; k++) g_f[GAIN_W-1-k] = frame[BASE+k];
         for (int k = 0; k < VOL_W; k++)  v_f[VOL_W-1-k]  = frame[BASE+GAIN_W+k];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gain_c[c] <= '0;
            vol_c[c]  <= '1;
         end else if (!en) begin
            gain_c[c] <= '0;
            vol_c[c]  <= '1;
         end else if (accept && slot == MY_SLOT) begin
            gain_c[c] <= g_f;
            vol_c[c]  <= v_f;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_stb  <= 1'b0;
         upd_slot <= '0;
      end else begin
         upd_stb <= accept;
         if (accept) upd_slot <= slot;
      end
   end

   AST_RSVD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (|frame[RSVD_HI:RSVD_LO])) |=> !upd_stb); // R4
   AST_PWR_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (bass_c == '0 && treb_c == '0 && gain_c == '0 && (&vol_c))); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !commit) |=> ($stable(bass_c) && $stable(treb_c) && $stable(gain_c) && $stable(vol_c))); // R10
   AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |=> !upd_stb); // R9
endmodule

// File: rtl/actl_decode.sv
module actl_decode
   import actl_pkg::*;
#(
   parameter int NCH       = 6,
   parameter int VOL_W     = 7,
   parameter int MAX_ATT   = 99,
   parameter int GAIN_STEP = 6,
   parameter int TONE_STEP = 2,
   parameter int GDB_W     = 5,
   parameter int TDB_W     = 5
) (
   input  logic [1:0][TONE_W-1:0]      tone_c,
   input  logic [NCH-1:0][GAIN_W-1:0]  gain_c,
   input  logic [NCH-1:0][VOL_W-1:0]   vol_c,
   output logic [1:0]                  tone_byp,
   output logic [1:0][TDB_W-1:0]       tone_db,
   output logic [NCH-1:0][GDB_W-1:0]   gain_db,
   output logic [NCH-1:0][VOL_W-1:0]   atten_db,
   output logic [NCH-1:0]              mute
);
   generate
      if (MAX_ATT >= (1 << VOL_W)) begin : g_bad_att
         $fatal(1, "actl_decode: MAX_ATT does not fit VOL_W");
      end
   endgenerate

   for (genvar t = 0; t < 2; t++) begin : g_tone
      always_comb begin
         int mag;
         mag         = int'(tone_c[t][TONE_W-2:0]) * TONE_STEP;
         tone_byp[t] = (tone_c[t] == '0);
         if (tone_c[t][TONE_W-1]) tone_db[t] = TDB_W'(mag);
         else                     tone_db[t] = TDB_W'(-mag);
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      always_comb begin
         mute[c]     = (int'(vol_c[c]) > MAX_ATT);
         atten_db[c] = mute[c] ? VOL_W'(MAX_ATT) : vol_c[c];
         gain_db[c]  = GDB_W'(int'(gain_c[c]) * GAIN_STEP);
      end
   end
endmodule

// File: rtl/actl_rx.sv
module actl_rx
   import actl_pkg::*;
#(
   parameter  int NCH         = 6,
   parameter  int VOL_W       = 7,
   parameter  int MAX_ATT     = 99,
   parameter  int GAIN_STEP   = 6,
   parameter  int TONE_STEP   = 2,
   parameter  int SYNC_STAGES = 2,
   localparam int GDB_W       = $clog2(3 * GAIN_STEP + 1),
   localparam int TDB_W       = $clog2(7 * TONE_STEP + 1) + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pwr_ok,
   input  logic                      ser_clk,
   input  logic                      ser_dat,
   output logic                      bass_byp,
   output logic [TDB_W-1:0]          bass_db,
   output logic                      treb_byp,
   output logic [TDB_W-1:0]          treb_db,
   output logic [NCH-1:0][GDB_W-1:0] gain_db,
   output logic [NCH-1:0][VOL_W-1:0] atten_db,
   output logic [NCH-1:0]            mute,
   output logic                      upd_stb,
   output logic [1:0]                upd_slot
);
   logic sclk, sclk_d, sdat, sdat_d, commit;
   logic [FRAME_W-1:0]          frame;
   logic [TONE_W-1:0]           bass_c, treb_c;
   logic [NCH-1:0][GAIN_W-1:0]  gain_c;
   logic [NCH-1:0][VOL_W-1:0]   vol_c;
   logic [1:0]                  tone_byp;
   logic [1:0][TDB_W-1:0]       tone_db;

   actl_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .din(ser_clk), .q(sclk), .q_d(sclk_d));
   actl_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .din(ser_dat), .q(sdat), .q_d(sdat_d));

   actl_frame_rx u_frame (
      .clk(clk), .rst_n(rst_n), .en(pwr_ok),
      .sclk(sclk), .sclk_d(sclk_d), .sdat(sdat), .sdat_d(sdat_d),
      .commit(commit), .frame(frame));

   actl_regfile #(.NCH(NCH), .VOL_W(VOL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .en(pwr_ok), .commit(commit), .frame(frame),
      .bass_c(bass_c), .treb_c(treb_c), .gain_c(gain_c), .vol_c(vol_c),
      .upd_stb(upd_stb), .upd_slot(upd_slot));

   actl_decode #(
      .NCH(NCH), .VOL_W(VOL_W), .MAX_ATT(MAX_ATT), .GAIN_STEP(GAIN_STEP),
      .TONE_STEP(TONE_STEP), .GDB_W(GDB_W), .TDB_W(TDB_W)
   ) u_dec (
      .tone_c({treb_c, bass_c}), .gain_c(gain_c), .vol_c(vol_c),
      .tone_byp(tone_byp), .tone_db(tone_db), .gain_db(gain_db),
      .atten_db(atten_db), .mute(mute));

   assign bass_byp = tone_byp[0];
   assign treb_byp = tone_byp[1];
   assign bass_db  = tone_db[0];
   assign treb_db  = tone_db[1];

   AST_MUTE_AT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |=> (&mute)); // R8
endmodule

// File: tb/actl_rx_tb.sv
module actl_rx_tb_top;
   localparam int NCH = 6;

   logic clk = 1'b0;
   logic rst_n, pwr_ok, ser_clk, ser_dat;
   logic bass_byp, treb_byp, upd_stb;
   logic [4:0] bass_db, treb_db;
   logic [NCH-1:0][4:0] gain_db;
   logic [NCH-1:0][6:0] atten_db;
   logic [NCH-1:0] mute;
   logic [1:0] upd_slot;

   always #5 clk = ~clk;

   actl_rx dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .bass_byp(bass_byp), .bass_db(bass_db), .treb_byp(treb_byp), .treb_db(treb_db),
      .gain_db(gain_db), .atten_db(atten_db), .mute(mute),
      .upd_stb(upd_stb), .upd_slot(upd_slot));

   int n_chk = 0, n_fail = 0, stb_cnt = 0, exp_stb = 0;
   bit done = 0;
   logic [1:0] last_slot = 2'b00, exp_slot = 2'b00;
   logic [3:0] m_bass, m_treb;
   logic [1:0] m_gain [NCH];
   logic [6:0] m_vol [NCH];

   always @(negedge clk) if (upd_stb) begin
      stb_cnt++;
      last_slot = upd_slot;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int tone_db_of(input logic [3:0] c);
      int m = int'(c[2:0]) * 2;
      return c[3] ? m : -m;
   endfunction

   function automatic int att_of(input logic [6:0] v);
      return (v > 7'd99) ? 99 : int'(v);
   endfunction

   task automatic model_defaults();
      m_bass = 4'b0000;
      m_treb = 4'b0000;
      for (int c = 0; c < NCH; c++) begin
         m_gain[c] = 2'b00;
         m_vol[c]  = 7'h7F;
      end
   endtask

   task automatic check_all(input string req);
      chk(bass_byp == (m_bass == 0), req, "bass bypass", bass_byp, m_bass == 0);
      chk($signed(bass_db) == tone_db_of(m_bass), req, "bass dB", $signed(bass_db), tone_db_of(m_bass));
      chk(treb_byp == (m_treb == 0), req, "treble bypass", treb_byp, m_treb == 0);
      chk($signed(treb_db) == tone_db_of(m_treb), req, "treble dB", $signed(treb_db), tone_db_of(m_treb));
      for (int c = 0; c < NCH; c++) begin
         chk(int'(gain_db[c]) == 6 * int'(m_gain[c]), req, $sformatf("gain ch%0d", c), gain_db[c], 6 * int'(m_gain[c]));
         chk(int'(atten_db[c]) == att_of(m_vol[c]), req, $sformatf("atten ch%0d", c), atten_db[c], att_of(m_vol[c]));
         chk(mute[c] == (m_vol[c] > 7'd99), req, $sformatf("mute ch%0d", c), mute[c], m_vol[c] > 7'd99);
      end
      chk(stb_cnt == exp_stb, "R9", "strobe count", stb_cnt, exp_stb);
      chk(last_slot == exp_slot, "R9", "strobe slot", last_slot, exp_slot);
   endtask

   // Bits change only while ser_clk is high; the commit fall happens while it is low.
   task automatic send(input logic [31:0] f, input int n);
      ser_dat = f[0];
      tick(6);
      for (int i = 0; i < n; i++) begin
         ser_clk = 1'b1; tick(6);
         ser_dat = (i < n - 1) ? f[i+1] : 1'b1; tick(6);
         ser_clk = 1'b0; tick(6);
      end
      ser_dat = 1'b0; tick(6);
   endtask

   function automatic logic [31:0] tone_frame(input logic [3:0] b, input logic [3:0] t, input logic [7:0] junk);
      logic [31:0] f = '0;
      for (int k = 0; k < 8; k++) f[k] = junk[k];
      for (int k = 0; k < 4; k++) begin
         f[8+k]  = b[3-k];
         f[12+k] = t[3-k];
      end
      return f;
   endfunction

   function automatic logic [31:0] chan_frame(input logic [1:0] s, input logic [1:0] g0, input logic [6:0] v0,
                                              input logic [1:0] g1, input logic [6:0] v1);
      logic [31:0] f = '0;
      for (int k = 0; k < 2; k++) begin
         f[k]   = g0[1-k];
         f[9+k] = g1[1-k];
      end
      for (int k = 0; k < 7; k++) begin
         f[2+k]  = v0[6-k];
         f[11+k] = v1[6-k];
      end
      f[22] = s[1];
      f[23] = s[0];
      return f;
   endfunction

   task automatic apply(input logic [31:0] f, input int n, input string req);
      logic [1:0] s = {f[22], f[23]};
      send(f, n);
      tick(12);
      if (pwr_ok && n == 24 && f[21:18] == 4'b0000) begin
         exp_stb++;
         exp_slot = s;
         if (s == 2'b00) begin
            m_bass = {f[8], f[9], f[10], f[11]};
            m_treb = {f[12], f[13], f[14], f[15]};
         end else begin
            int c0 = 2 * (int'(s) - 1);
            m_gain[c0]   = {f[0], f[1]};
            m_vol[c0]    = {f[2], f[3], f[4], f[5], f[6], f[7], f[8]};
            m_gain[c0+1] = {f[9], f[10]};
            m_vol[c0+1]  = {f[11], f[12], f[13], f[14], f[15], f[16], f[17]};
         end
      end
      check_all(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] f;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; pwr_ok = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0;
      model_defaults();
      tick(5);
      rst_n = 1'b1;
      tick(5);
      check_all("R8 reset defaults");
      // R8: a frame sent while power-good is low is ignored
      apply(tone_frame(4'b1111, 4'b1111, 8'h00), 24, "R8 frame while power low");
      pwr_ok = 1'b1;
      tick(5);
      // R5 tone extremes and encodings
      apply(tone_frame(4'b1111, 4'b0111, 8'hA5), 24, "R5 +14/-14");
      apply(tone_frame(4'b0000, 4'b1000, 8'h3C), 24, "R5 bypass and 0 dB");
      apply(tone_frame(4'b0001, 4'b1001, 8'hFF), 24, "R5 -2/+2");
      // R6/R7 channel fields and volume boundary
      apply(chan_frame(2'b01, 2'b11, 7'd0, 2'b01, 7'd99), 24, "R6 R7 R1 front pair");
      apply(chan_frame(2'b10, 2'b10, 7'd100, 2'b00, 7'd127), 24, "R7 mute above 99");
      apply(chan_frame(2'b11, 2'b01, 7'd42, 2'b11, 7'd1), 24, "R10 R6 rear pair");
      // R4: reserved bits set drops the frame
      f = chan_frame(2'b01, 2'b00, 7'd5, 2'b00, 7'd5);
      f[19] = 1'b1;
      apply(f, 24, "R4 reserved bit dropped");
      // R3: wrong bit counts dropped, then R2: counter restarts
      apply(chan_frame(2'b01, 2'b10, 7'd7, 2'b10, 7'd8), 23, "R3 short frame");
      apply(chan_frame(2'b01, 2'b10, 7'd7, 2'b10, 7'd8), 25, "R3 long frame");
      apply(chan_frame(2'b01, 2'b10, 7'd7, 2'b10, 7'd8), 24, "R2 frame after discard");
      // random frames
      for (int i = 0; i < 60; i++) begin
         logic [1:0] s = 2'($urandom % 4);
         if (s == 2'b00) f = tone_frame(4'($urandom), 4'($urandom), 8'($urandom));
         else f = chan_frame(s, 2'($urandom), 7'($urandom), 2'($urandom), 7'($urandom));
         if ($urandom % 10 == 0) f[18 + ($urandom % 4)] = 1'b1;
         apply(f, ($urandom % 12 == 0) ? 22 + int'($urandom % 2) : 24, "R10 R1 random");
      end
      // R8: power-good low restores defaults
      pwr_ok = 1'b0;
      tick(4);
      model_defaults();
      check_all("R8 power low defaults");
      pwr_ok = 1'b1;
      tick(4);
      apply(chan_frame(2'b11, 2'b01, 7'd50, 2'b10, 7'd60), 24, "R8 recovery");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule